// File: doc/BRIEF.md
# Enabled Two-Bit Up/Down Counter Built on JK Cells

This block counts modulo four in either direction. Two JK storage cells hold the count. The upper cell holds the more significant bit and the lower cell holds the less significant bit. A count-enable input gates every change. A direction input picks whether an enabled clock edge moves the count one step forward or one step back. The count wraps at both ends.

No adder forms the next count. Each cell takes its J and K inputs from a small set of excitation equations. Both inputs of the low cell follow the enable. Both inputs of the high cell are asserted on two kinds of enabled edge: an up-step while the low bit is 1, and a down-step while the low bit is 0. A synchronous reset returns the count to zero.

The block is meant as a small direction-selectable sequencer. The direction input may change on any cycle, and the next enabled edge simply applies the new direction.

Top module: `updown_jk_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `state` is 2'b00 after that edge, whatever `en` and `dir` are.
- R2: When `en` is 0 at an edge (and `rst` is 0), `state` keeps its value for both values of `dir`.
- R3: With `en`=1 and `dir`=1 on successive edges, `state` runs 00, 01, 10, 11 and then back to 00.
- R4: With `en`=1 and `dir`=0 on successive edges, `state` runs 00, 11, 10, 01 and then back to 00.
- R5: The low bit `state[0]` inverts on every enabled edge and on no other edge outside reset.
- R6: The high bit `state[1]` inverts only on an enabled edge where either `dir`=1 and `state[0]`=1, or `dir`=0 and `state[0]`=0.
- R7: Reversing `dir` between two enabled edges gives exactly one step in the new direction at the second edge, with no skipped or repeated code.
- R8: For every present state (0 to 3), `en` value and `dir` value, the next `state` equals the present state plus 1, minus 1, or plus 0, modulo 4. The choice is up when `en`=1 and `dir`=1, down when `en`=1 and `dir`=0, and hold when `en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the count to 00 |
| en | input | 1 | Count enable; 0 holds the count |
| dir | input | 1 | Direction; 1 counts up, 0 counts down |
| state | output | 2 | Present count; bit 1 is the more significant bit |

## Verification
The bound checker examines every clock edge. It confirms reset to zero, holding when disabled, single-step moves up and down with modulo-4 wrap, and the toggle conditions of each bit taken on its own. The checker cannot show whole sequences. Those come from the bench's scenarios: full laps in each direction, direction reversals between adjacent enabled edges, long disabled stretches with a toggling direction input, and an exhaustive sweep of all sixteen combinations of present state, enable and direction against a modulo-4 arithmetic model.

// File: rtl/updown_jk_pkg.sv
package updown_jk_pkg;

   // Drive pair presented to one JK storage cell
   typedef struct packed {
      logic j;
      logic k;
   } jk_drive_t;

   // Implementation variant of the JK storage cell
   typedef enum logic {
      JK_CHAR_EQ = 1'b0,   // characteristic equation Q+ = J&~Q | ~K&Q
      JK_CASE    = 1'b1    // explicit hold/reset/set/toggle decode
   } jk_style_e;

endpackage

// File: rtl/jk_cell.sv
module jk_cell
   import updown_jk_pkg::*;
#(
   parameter jk_style_e STYLE   = JK_CHAR_EQ,
   parameter logic      RST_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst,
   input  jk_drive_t drv,
   output logic      q
);

   logic q_nxt;

   generate
      if (STYLE == JK_CHAR_EQ) begin : g_char
         always_comb q_nxt = (drv.j & ~q) | (~drv.k & q);
      end else begin : g_case
         always_comb begin
            unique case ({drv.j, drv.k})
               2'b00:   q_nxt = q;
               2'b01:   q_nxt = 1'b0;
               2'b10:   q_nxt = 1'b1;
               default: q_nxt = ~q;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= q_nxt;
   end

endmodule

// File: rtl/jk_excite.sv
module jk_excite
   import updown_jk_pkg::*;
(
   input  logic      en,
   input  logic      dir,
   input  logic      lsb,
   output jk_drive_t drv_hi,
   output jk_drive_t drv_lo
);

   logic hi_flip;

   // high bit flips on enabled up-step from lsb=1 or down-step from lsb=0
   always_comb begin
      hi_flip  = (lsb & en & dir) | (~lsb & en & ~dir);
      drv_hi.j = hi_flip;
      drv_hi.k = hi_flip;
      drv_lo.j = en;
      drv_lo.k = en;
   end

endmodule

// File: rtl/updown_jk_counter.sv
module updown_jk_counter
   import updown_jk_pkg::*;
#(
   parameter int        STATE_W    = 2,
   parameter jk_style_e CELL_STYLE = JK_CHAR_EQ
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               dir,
   output logic [STATE_W-1:0] state
);

   localparam int HI = STATE_W - 1;
   localparam int LO = 0;

   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("updown_jk_counter: STATE_W must be 2, got %0d", STATE_W);
      end
   endgenerate

   jk_drive_t drv_hi;
   jk_drive_t drv_lo;
   logic      q_hi;
   logic      q_lo;

   jk_excite u_excite (
      .en     (en),
      .dir    (dir),
      .lsb    (q_lo),
      .drv_hi (drv_hi),
      .drv_lo (drv_lo)
   );

   jk_cell #(.STYLE(CELL_STYLE), .RST_VAL(1'b0)) u_cell_hi (
      .clk (clk),
      .rst (rst),
      .drv (drv_hi),
      .q   (q_hi)
   );

   jk_cell #(.STYLE(CELL_STYLE), .RST_VAL(1'b0)) u_cell_lo (
      .clk (clk),
      .rst (rst),
      .drv (drv_lo),
      .q   (q_lo)
   );

   always_comb begin
      state     = '0;
      state[HI] = q_hi;
      state[LO] = q_lo;
   end

endmodule

// File: rtl/updown_jk_counter_chk.sv
module updown_jk_counter_chk #(
   parameter int STATE_W = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               en,
   input logic               dir,
   input logic [STATE_W-1:0] state
);

   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> state == '0);

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !en |=> state == $past(state));

   assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
      (en && dir) |=> state == STATE_W'($past(state) + 1'b1));

   assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
      (en && !dir) |=> state == STATE_W'($past(state) - 1'b1));

   assert_lo_toggle_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (state[0] != $past(state[0])) == $past(en));

   assert_hi_toggle_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (state[1] != $past(state[1])) ==
               ($past(en) && ($past(dir) == $past(state[0]))));

endmodule

bind updown_jk_counter updown_jk_counter_chk #(.STATE_W(STATE_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .dir   (dir),
   .state (state)
);

// File: tb/updown_jk_counter_test.sv
`timescale 1ns/1ps
module updown_jk_counter_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       dir = 1'b0;
   logic [1:0] state;

   int checks = 0;
   int errors = 0;
   logic [1:0] model = 2'b00;
   logic [1:0] exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   updown_jk_counter uut (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .dir   (dir),
      .state (state)
   );

   // monitor: pops one expected item per edge once the driver has queued it
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (state !== e) begin
            errors++;
            $display("FAIL %s state actual %b expected %b", t, state, e);
         end
      end
   end

   task automatic do_reset(input logic e_v, input logic d_v);
      @(negedge clk);
      rst = 1'b1; en = e_v; dir = d_v;
      model = 2'b00;
      exp_q.push_back(model); tag_q.push_back("R1");
   endtask

   task automatic step(input logic e_v, input logic d_v, input string t);
      @(negedge clk);
      rst = 1'b0; en = e_v; dir = d_v;
      if (e_v) model = d_v ? model + 2'd1 : model - 2'd1;
      exp_q.push_back(model); tag_q.push_back(t);
   endtask

   initial begin
      do_reset(1'b1, 1'b1);                       // R1 with enable active
      // up lap R3
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R3");
      do_reset(1'b0, 1'b0);
      // down lap R4
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R4");
      // hold with dir toggling R2
      for (int i = 0; i < 6; i++) step(1'b0, i[0], "R2");
      // reversal on adjacent edges R7
      for (int i = 0; i < 8; i++) step(1'b1, i[0], "R7");
      step(1'b1, 1'b1, "R7"); step(1'b1, 1'b1, "R7");
      step(1'b1, 1'b0, "R7"); step(1'b1, 1'b0, "R7");
      // low-bit and high-bit toggle patterns R5 R6
      for (int i = 0; i < 4; i++) step(i[1], 1'b1, "R5");
      for (int i = 0; i < 4; i++) step(1'b1, ~i[1], "R6");
      // reset in the middle of a count R1
      step(1'b1, 1'b1, "R3");
      do_reset(1'b1, 1'b0);
      // exhaustive sweep R8
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 2; e++) begin
            for (int x = 0; x < 2; x++) begin
               do_reset(1'b0, 1'b0);
               for (int k = 0; k < s; k++) step(1'b1, 1'b1, "R8");
               step(e[0], x[0], "R8");
            end
         end
      end
      step(1'b0, 1'b0, "R2");
      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule